// File: doc/BRIEF.md
# Predicated Slot Enable Decoder

This block turns the header word of a predicated 256-bit instruction block into a per-slot execute permission. A block holds eight 32-bit slots. The header sits in the first slot and the other seven carry instructions. The header carries two independent predicate sets. Each set names one of sixteen condition flags, gives a polarity bit, and lists the slots it governs. The decoder reads the live condition-flag vector and produces a seven-bit enable mask, with one bit for each instruction slot.

The two sets let one block mix instructions guarded by two different flags, or by one flag in both senses. A slot must be claimed by at most one set. If both sets claim the same slot, the header is illegal: the decoder raises an error and withholds every enable. A slot that neither set claims always runs. The result is captured on the cycle the header-valid strobe is sampled. It is held until the next strobe, so the issue stage can consume it at its own pace.

Top module: `pse_decoder`

## Requirements
- R1: While reset is asserted, and until the first header-valid strobe after it, `slot_en_o` is all zeros and `ovl_err_o` is 0.
- R2: Each set selects its flag with a 4-bit index into `cond_flags_i`. Set A uses header bits [3:0] and set B uses bits [15:12]. Any of the sixteen flags can be selected.
- R3: When the polarity bit of a set is 0 (set A bit 4, set B bit 16), a slot claimed by that set is enabled exactly when the selected flag is 1.
- R4: When the polarity bit of a set is 1, a slot claimed by that set is enabled exactly when the selected flag is 0.
- R5: The slot mask of set A is header bits [11:5] and the slot mask of set B is bits [23:17]. In both masks and in `slot_en_o`, bit i stands for instruction slot i+1, counted after the header slot.
- R6: When the masks do not overlap, a slot whose bit is clear in both masks is enabled, whatever the flags.
- R7: When the two masks share at least one set bit, `ovl_err_o` is 1 and `slot_en_o` is all zeros. Otherwise `ovl_err_o` is 0.
- R8: The outputs take the decoded value one clock after the rising edge that samples `hdr_vld_i` high. In cycles without the strobe, changes on `hdr_word_i` or `cond_flags_i` leave the outputs unchanged.
- R9: Header bits [31:24] have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| hdr_vld_i | input | 1 | Header-valid strobe; a header is captured on each edge where it is high |
| hdr_word_i | input | 32 | Header word of the predicated block |
| cond_flags_i | input | 16 | Current condition-flag vector |
| slot_en_o | output | 7 | Registered execute enable, bit i for instruction slot i+1 |
| ovl_err_o | output | 1 | Registered illegal-overlap indication |

## Verification
All of the decoder's state is in the two output registers, so a corrupted capture shows at the ports on the first cycle after the strobe. A wrong flag index, or a slot order that is swapped or off by one, shows as a single wrong enable bit only when the selected flag values differ. For that reason the flag vectors are one-hot and the masks are single-slot, so that each bit of the header has a visible effect. A hold register that reloads without a strobe shows within one cycle once the flags move between strobes. Overlap handling shows both in the error bit and in a mask that fails to clear.

// File: rtl/pse_pkg.sv
package pse_pkg;
  parameter int unsigned NUM_FLAGS = 16;
  parameter int unsigned NUM_SLOTS = 8;
  parameter int unsigned NUM_SETS  = 2;
  parameter int unsigned HDR_W     = 32;

  localparam int unsigned SEL_W  = $clog2(NUM_FLAGS);
  localparam int unsigned MASK_W = NUM_SLOTS - 1;
  localparam int unsigned SET_W  = SEL_W + 1 + MASK_W;

  // One predicate set as laid out in the header, low bits first:
  // flag index, polarity, slot mask.
  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic              inv;
    logic [SEL_W-1:0]  sel;
  } pset_t;

  typedef logic [MASK_W-1:0] slot_vec_t;
endpackage

// File: rtl/pse_rst_sync.sv
module pse_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/pse_set_eval.sv
module pse_set_eval
  import pse_pkg::*;
(
  input  pset_t                set_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  output slot_vec_t            claim_o,
  output slot_vec_t            grant_o
);
  logic cond;

  always_comb begin
    cond    = flags_i[set_i.sel] ^ set_i.inv;
    claim_o = set_i.mask;
    grant_o = cond ? set_i.mask : '0;
  end
endmodule

// File: rtl/pse_merge.sv
module pse_merge
  import pse_pkg::*;
(
  input  slot_vec_t claim_i [NUM_SETS],
  input  slot_vec_t grant_i [NUM_SETS],
  output slot_vec_t en_o,
  output logic      err_o
);
  slot_vec_t seen;
  slot_vec_t multi;
  slot_vec_t granted;

  always_comb begin
    seen    = '0;
    multi   = '0;
    granted = '0;
    for (int s = 0; s < NUM_SETS; s++) begin
      multi   = multi | (seen & claim_i[s]);
      seen    = seen | claim_i[s];
      granted = granted | grant_i[s];
    end
    err_o = |multi;
    en_o  = err_o ? '0 : (~seen | granted);
  end
endmodule

// File: rtl/pse_decoder.sv
module pse_decoder
  import pse_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hdr_vld_i,
  input  logic [HDR_W-1:0]     hdr_word_i,
  input  logic [NUM_FLAGS-1:0] cond_flags_i,
  output logic [MASK_W-1:0]    slot_en_o,
  output logic                 ovl_err_o
);
  logic      rst_n;
  pset_t     sets  [NUM_SETS];
  slot_vec_t claim [NUM_SETS];
  slot_vec_t grant [NUM_SETS];
  slot_vec_t en_nxt;
  logic      err_nxt;
  slot_vec_t en_d,  en_q;
  logic      err_d, err_q;

  pse_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    assign sets[s] = pset_t'(hdr_word_i[s*SET_W +: SET_W]);
    pse_set_eval u_eval (
      .set_i   (sets[s]),
      .flags_i (cond_flags_i),
      .claim_o (claim[s]),
      .grant_o (grant[s])
    );
  end

  pse_merge u_merge (
    .claim_i (claim),
    .grant_i (grant),
    .en_o    (en_nxt),
    .err_o   (err_nxt)
  );

  // next state: load on strobe, otherwise hold
  always_comb begin
    en_d  = en_q;
    err_d = err_q;
    if (hdr_vld_i) begin
      en_d  = en_nxt;
      err_d = err_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      err_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      err_q <= err_d;
    end
  end

  assign slot_en_o = en_q;
  assign ovl_err_o = err_q;

  // ---------------- assertions ----------------
  slot_vec_t hdr_cov;
  always_comb begin
    hdr_cov = '0;
    for (int s = 0; s < NUM_SETS; s++) hdr_cov = hdr_cov | sets[s].mask;
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !hdr_vld_i |=> ($stable(slot_en_o) && $stable(ovl_err_o)));

  p_err_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    ovl_err_o |-> (slot_en_o == '0));

  p_uncov_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hdr_vld_i && !err_nxt) |=> (&(slot_en_o | $past(hdr_cov))));

  p_sense_pos_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hdr_vld_i && !err_nxt && sets[0].mask[0] && !sets[0].inv)
      |=> (slot_en_o[0] == $past(cond_flags_i[sets[0].sel])));

  p_sense_neg_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (hdr_vld_i && !err_nxt && sets[0].mask[0] && sets[0].inv)
      |=> (slot_en_o[0] == !$past(cond_flags_i[sets[0].sel])));

  if (NUM_SETS == 2) begin : g_pair_chk
    p_ovl_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
      hdr_vld_i |=> (ovl_err_o == $past(|(sets[0].mask & sets[1].mask))));
  end
endmodule

// File: tb/pse_decoder_tb_top.sv
`timescale 1ns/1ps
module pse_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] hdr = '0;
  logic [15:0] flags = '0;
  logic [6:0]  en;
  logic        err;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic       pend_q = 1'b0;
  logic [7:0] last_exp = '0;

  always #2 clk = ~clk;

  pse_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hdr_vld_i(vld), .hdr_word_i(hdr),
    .cond_flags_i(flags), .slot_en_o(en), .ovl_err_o(err)
  );

  function automatic logic [31:0] mk(input logic [3:0] sa, input logic ia, input logic [6:0] ma,
                                     input logic [3:0] sb, input logic ib, input logic [6:0] mb,
                                     input logic [7:0] top);
    return {top, mb, ib, sb, ma, ia, sa};
  endfunction

  function automatic logic [7:0] model(input logic [31:0] h, input logic [15:0] f);
    logic [6:0] a, b, e;
    logic ca, cb;
    a = h[11:5];
    b = h[23:17];
    if ((a & b) != 0) return 8'h80;
    ca = f[h[3:0]] ^ h[4];
    cb = f[h[15:12]] ^ h[16];
    e = ~(a | b) | (ca ? a : 7'h0) | (cb ? b : 7'h0);
    return {1'b0, e};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s err/en act=%b_%b exp=%b_%b", tag, act[7], act[6:0], expv[7], expv[6:0]);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] h, input logic [15:0] f);
    @(negedge clk); #1;
    vld = 1'b1; hdr = h; flags = f;
    last_exp = model(h, f);
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      vld = 1'b0;
    end
  endtask

  // monitor
  always @(posedge clk) pend_q <= vld;
  always @(negedge clk) begin
    if (pend_q) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R8 unexpected result act=%b_%b exp=none", err, en);
      end else begin
        check(tag_q.pop_front(), {err, en}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {err, en}, 8'h00);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {err, en}, 8'h00);

    // R2/R3: every flag index for both sets, one-hot flags
    for (int k = 0; k < 16; k++) begin
      apply("R2 setA hit", mk(4'(k), 0, 7'h7F, 4'h0, 0, 7'h00, 8'h00), 16'(1 << k));
      apply("R2 setA miss", mk(4'(k), 0, 7'h7F, 4'h0, 0, 7'h00, 8'h00), ~16'(1 << k));
      apply("R2 setB hit", mk(4'h0, 0, 7'h00, 4'(k), 0, 7'h7F, 8'h00), 16'(1 << k));
      apply("R2 setB miss", mk(4'h0, 0, 7'h00, 4'(k), 0, 7'h7F, 8'h00), ~16'(1 << k));
    end
    idle(2);
    // R4 inverted sense
    apply("R4 setA inv flag0", mk(4'h5, 1, 7'h0F, 4'h9, 1, 7'h70, 8'h00), 16'h0200);
    apply("R4 setB inv flag1", mk(4'h5, 1, 7'h0F, 4'h9, 0, 7'h70, 8'h00), 16'h0000);
    apply("R3 mixed", mk(4'h3, 0, 7'h55, 4'h3, 1, 7'h2A, 8'h00), 16'h0008);
    idle(2);
    // R5 slot order: single slot, false flag
    for (int i = 0; i < 7; i++) begin
      apply("R5 setA slot", mk(4'h2, 0, 7'(1 << i), 4'h0, 0, 7'h00, 8'h00), 16'h0000);
      apply("R5 setB slot", mk(4'h0, 0, 7'h00, 4'h7, 1, 7'(1 << i), 8'h00), 16'h0080);
    end
    idle(1);
    // R6 uncovered slots
    apply("R6 empty masks", mk(4'hF, 0, 7'h00, 4'hE, 1, 7'h00, 8'h00), 16'h4000);
    apply("R6 partial", mk(4'h1, 0, 7'h03, 4'h2, 0, 7'h0C, 8'h00), 16'h0000);
    idle(2);
    // R7 overlap
    for (int i = 0; i < 7; i++)
      apply("R7 single overlap", mk(4'h0, 0, 7'(1 << i), 4'h0, 1, 7'(1 << i), 8'h00), 16'hFFFF);
    apply("R7 full overlap", mk(4'h0, 0, 7'h7F, 4'h1, 0, 7'h7F, 8'h00), 16'hFFFF);
    apply("R7 cleared", mk(4'h0, 0, 7'h01, 4'h1, 0, 7'h02, 8'h00), 16'h0003);
    idle(2);
    // R9 top bits ignored
    apply("R9 top ones", mk(4'h4, 0, 7'h11, 4'h8, 1, 7'h22, 8'hFF), 16'h0110);
    apply("R9 top pattern", mk(4'h4, 0, 7'h11, 4'h8, 1, 7'h22, 8'hA5), 16'h0010);
    idle(2);
    // R8 hold: inputs move without strobe
    apply("R8 capture", mk(4'h6, 0, 7'h3C, 4'h0, 0, 7'h00, 8'h00), 16'h0040);
    idle(1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      flags = ~flags;
      hdr   = hdr ^ 32'h00FF_FFFF;
      @(negedge clk);
      check("R8 hold", {err, en}, last_exp);
    end
    // mixed patterns, back to back
    for (int i = 0; i < 60; i++) begin
      logic [31:0] h;
      h = $urandom;
      if (i % 3 != 0) h[23:17] = h[23:17] & ~h[11:5];
      apply("R3 R4 R7 mixed", h, 16'($urandom));
    end
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R8 pending act=%0d exp=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule